// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Unit

This unit is the interrupt front end of a 16550-style serial port. It gathers four interrupt sources and keeps a pending flag for each. The sources are receive line errors, received data ready, receive character timeout, and transmit holding register empty. Each flag is masked by an enable register. The unit reports the most urgent enabled source as an encoded identification byte. It also drives one active-high interrupt request toward the system interrupt controller.

The serial shifters, FIFOs and baud generator sit outside this unit and reach it only as status inputs and strobes. The receive-timeout timer is built in. It counts baud ticks against a character time supplied as an input, and it fires after a parameterised number of idle character times, four by default. Each source has its own clearing access. A line-status read clears line errors and a receive-buffer read clears received data and timeout. A transmit write clears transmit-empty. A read of the identification register also clears transmit-empty, but only when transmit-empty is the source it reports.

Top module: `uart_irq_ident`

## Requirements
- R1: The enable register holds three bits: bit 0 enables received-data and timeout, bit 1 enables transmit-empty, and bit 2 enables line status. Bits 7:3 always read back as zero.
- R2: A source whose enable bit is 0 never shows in the identification byte and never raises `irq`. Its pending flag is kept, and it is reported once its enable bit is set.
- R3: Identification bit 0 is an active-low pending flag. `irq` always equals its inverse. With nothing pending the byte reads 0x01. Bits 7:4 always read 0.
- R4: Identification bits 3:1 carry the source code, most urgent first: 011 line status (0x06), 010 received data (0x04), 110 timeout (0x0C), 001 transmit-empty (0x02). When received data and timeout are both active, received data is reported.
- R5: Any overrun, parity, framing or break event sets the line-status flag, and a line-status read clears it. An error event in the same cycle as the read leaves the flag set.
- R6: The received-data flag follows `rx_ready` one cycle later. A receive-buffer read clears it in the following cycle even while `rx_ready` stays high, and it re-asserts one cycle after that.
- R7: In FIFO mode with the receive FIFO non-empty, the timeout flag sets after TIMEOUT_CHARS×`char_time` baud ticks with no push or pop. With the defaults and `char_time`=2, a tick every cycle after a push sets it on the 8th edge. The timer restarts on a push or pop, is held at zero while the FIFO is empty, and stops once it expires. A receive-buffer read clears the timeout flag, and the read wins over expiry.
- R8: The transmit-empty flag sets on a rising edge of `thr_empty`, or when enable bit 1 is written from 0 to 1 while `thr_empty` is high. A transmit write clears it.
- R9: An identification read clears transmit-empty only when 001 is the reported code in that cycle. The next source is reported in the following cycle.
- R10: When `fifo_mode` is 0, code 110 never appears and the timeout timer is held at zero.
- R11: Reset clears the enable register and all pending flags, so the identification byte reads 0x01 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | 1 = FIFO mode, 0 = single-character mode |
| ls_overrun | input | 1 | Overrun error event |
| ls_parity | input | 1 | Parity error event |
| ls_framing | input | 1 | Framing error event |
| ls_break | input | 1 | Break detected event |
| rx_ready | input | 1 | Data available / trigger level reached |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_push | input | 1 | Character written into receive FIFO |
| rx_pop | input | 1 | Character removed from receive FIFO |
| baud_tick | input | 1 | One baud-rate tick |
| char_time | input | CHAR_W | Character time in baud ticks |
| thr_empty | input | 1 | Transmit holding register empty |
| ier_wr | input | 1 | Enable register write strobe |
| wdata | input | REG_W | Write data |
| thr_wr | input | 1 | Transmit holding register write strobe |
| iir_rd | input | 1 | Identification register read strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| ier_rdata | output | REG_W | Enable register read value |
| iir_rdata | output | REG_W | Identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a new line error arriving in the very cycle its clearing line-status read occurs. The second pair is an identification read made while transmit-empty is pending but a more urgent source is being reported. The bench provokes the first by driving a framing event and the line-status read on the same edge; the flag must survive with code 0x06 still shown. It provokes the second by reading the identification register while a line error outranks transmit-empty. Once the line error is cleared, transmit-empty must still read 0x02, and only a read taken while 0x02 is shown may clear it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   typedef enum logic [2:0] {
      IID_NONE = 3'b000,
      IID_THRE = 3'b001,
      IID_RDA  = 3'b010,
      IID_LS   = 3'b011,
      IID_TMO  = 3'b110
   } iid_e;

   localparam int EN_RDA  = 0;
   localparam int EN_THRE = 1;
   localparam int EN_LS   = 2;
   localparam int EN_BITS = 3;

   typedef struct packed {
      logic ls;
      logic rda;
      logic tmo;
      logic thre;
   } src_t;

endpackage

// File: rtl/uart_irq_tmo.sv
module uart_irq_tmo #(
   parameter int CHAR_W        = 12,
   parameter int TIMEOUT_CHARS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_mode,
   input  logic              baud_tick,
   input  logic              rx_push,
   input  logic              rx_pop,
   input  logic              rx_empty,
   input  logic [CHAR_W-1:0] char_time,
   output logic              hit
);
   localparam int MUL_W = $clog2(TIMEOUT_CHARS + 1);
   localparam int TO_W  = CHAR_W + MUL_W;

   logic [TO_W-1:0] limit;
   logic [TO_W-1:0] cnt;
   logic            restart;

   assign limit   = TO_W'(char_time) * TO_W'(TIMEOUT_CHARS);
   assign restart = !fifo_mode || rx_empty || rx_push || rx_pop;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart) begin
         cnt <= '0;
      end else if (baud_tick && (cnt != limit)) begin
         cnt <= cnt + TO_W'(1);
      end
   end

   assign hit = !restart && baud_tick && (limit != '0) &&
                (cnt == (limit - TO_W'(1)));
endmodule

// File: rtl/uart_irq_srcs.sv
module uart_irq_srcs
   import uart_irq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ls_evt,
   input  logic lsr_rd,
   input  logic rx_ready,
   input  logic rbr_rd,
   input  logic tmo_hit,
   input  logic thr_empty,
   input  logic thre_en_rise,
   input  logic thr_wr,
   input  logic thre_rd_clr,
   output src_t pend
);
   logic thr_q;
   logic thre_set;

   assign thre_set = thr_empty && (!thr_q || thre_en_rise);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend  <= '0;
         thr_q <= 1'b0;
      end else begin
         thr_q <= thr_empty;

         if (ls_evt)      pend.ls <= 1'b1;
         else if (lsr_rd) pend.ls <= 1'b0;

         pend.rda <= rx_ready && !rbr_rd;

         if (rbr_rd)       pend.tmo <= 1'b0;
         else if (tmo_hit) pend.tmo <= 1'b1;

         if (thre_set)                  pend.thre <= 1'b1;
         else if (thr_wr || thre_rd_clr) pend.thre <= 1'b0;
      end
   end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
(
   input  src_t                pend,
   input  logic [EN_BITS-1:0]  ier,
   input  logic                fifo_mode,
   output iid_e                iid,
   output logic                active
);
   always_comb begin
      iid = IID_NONE;
      if (pend.ls && ier[EN_LS])                       iid = IID_LS;
      else if (pend.rda && ier[EN_RDA])                iid = IID_RDA;
      else if (pend.tmo && ier[EN_RDA] && fifo_mode)   iid = IID_TMO;
      else if (pend.thre && ier[EN_THRE])              iid = IID_THRE;
   end

   assign active = (iid != IID_NONE);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int CHAR_W        = 12,
   parameter int TIMEOUT_CHARS = 4,
   parameter int REG_W         = 8,
   parameter bit HAS_TIMEOUT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_mode,
   input  logic              ls_overrun,
   input  logic              ls_parity,
   input  logic              ls_framing,
   input  logic              ls_break,
   input  logic              rx_ready,
   input  logic              rx_empty,
   input  logic              rx_push,
   input  logic              rx_pop,
   input  logic              baud_tick,
   input  logic [CHAR_W-1:0] char_time,
   input  logic              thr_empty,
   input  logic              ier_wr,
   input  logic [REG_W-1:0]  wdata,
   input  logic              thr_wr,
   input  logic              iir_rd,
   input  logic              lsr_rd,
   input  logic              rbr_rd,
   output logic [REG_W-1:0]  ier_rdata,
   output logic [REG_W-1:0]  iir_rdata,
   output logic              irq
);
   localparam int PAD_W = REG_W - 4;

   if (REG_W < 4) begin : g_bad_reg_w
      $error("uart_irq_ident: REG_W must be at least 4");
   end
   if (CHAR_W < 1) begin : g_bad_char_w
      $error("uart_irq_ident: CHAR_W must be at least 1");
   end
   if (TIMEOUT_CHARS < 1) begin : g_bad_tmo
      $error("uart_irq_ident: TIMEOUT_CHARS must be at least 1");
   end

   logic [EN_BITS-1:0] ier;
   logic               thre_en_rise;
   logic               tmo_hit;
   logic               active;
   logic               ls_evt;
   iid_e               iid;
   src_t               pend;
   logic               unused_wdata;

   assign unused_wdata = ^wdata[REG_W-1:EN_BITS];
   assign ls_evt       = ls_overrun || ls_parity || ls_framing || ls_break;
   assign thre_en_rise = ier_wr && wdata[EN_THRE] && !ier[EN_THRE];

   always_ff @(posedge clk) begin
      if (!rst_n)      ier <= '0;
      else if (ier_wr) ier <= wdata[EN_BITS-1:0];
   end

   if (HAS_TIMEOUT) begin : g_tmo
      uart_irq_tmo #(
         .CHAR_W        (CHAR_W),
         .TIMEOUT_CHARS (TIMEOUT_CHARS)
      ) u_tmo (
         .clk       (clk),
         .rst_n     (rst_n),
         .fifo_mode (fifo_mode),
         .baud_tick (baud_tick),
         .rx_push   (rx_push),
         .rx_pop    (rx_pop),
         .rx_empty  (rx_empty),
         .char_time (char_time),
         .hit       (tmo_hit)
      );
   end else begin : g_no_tmo
      logic unused_tmo;
      assign unused_tmo = ^{baud_tick, rx_push, rx_pop, rx_empty, char_time};
      assign tmo_hit    = 1'b0;
   end

   uart_irq_srcs u_srcs (
      .clk          (clk),
      .rst_n        (rst_n),
      .ls_evt       (ls_evt),
      .lsr_rd       (lsr_rd),
      .rx_ready     (rx_ready),
      .rbr_rd       (rbr_rd),
      .tmo_hit      (tmo_hit),
      .thr_empty    (thr_empty),
      .thre_en_rise (thre_en_rise),
      .thr_wr       (thr_wr),
      .thre_rd_clr  (iir_rd && (iid == IID_THRE)),
      .pend         (pend)
   );

   uart_irq_prio u_prio (
      .pend      (pend),
      .ier       (ier),
      .fifo_mode (fifo_mode),
      .iid       (iid),
      .active    (active)
   );

   assign ier_rdata = {{(REG_W-EN_BITS){1'b0}}, ier};
   assign iir_rdata = {{PAD_W{1'b0}}, iid, !active};
   assign irq       = active;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       fifo_mode,
   input logic       ls_overrun,
   input logic       ls_parity,
   input logic       ls_framing,
   input logic       ls_break,
   input logic       thr_empty,
   input logic       thr_wr,
   input logic       iir_rd,
   input logic       lsr_rd,
   input logic       rbr_rd,
   input logic [7:0] ier_rdata,
   input logic [7:0] iir_rdata,
   input logic       irq
);
   p_ier_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ier_rdata[7:3] == 5'b0);

   p_ls_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ier_rdata[2] |-> iir_rdata[3:1] != 3'b011);

   p_rx_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ier_rdata[0] |-> (iir_rdata[3:1] != 3'b010 && iir_rdata[3:1] != 3'b110));

   p_irq_vs_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq == !iir_rdata[0] && iir_rdata[7:4] == 4'b0);

   p_lsr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !(ls_overrun || ls_parity || ls_framing || ls_break))
      |=> iir_rdata[3:1] != 3'b011);

   p_ls_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ls_overrun || ls_parity || ls_framing || ls_break) && ier_rdata[2]
      |=> iir_rdata[3:1] == 3'b011 || !ier_rdata[2]);

   p_rbr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rbr_rd |=> (iir_rdata[3:1] != 3'b010 && iir_rdata[3:1] != 3'b110));

   p_thr_wr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_wr && !thr_empty) |=> iir_rdata[3:1] != 3'b001);

   p_iir_rd_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_rd && iir_rdata[3:1] == 3'b001 && !thr_empty)
      |=> iir_rdata[3:1] != 3'b001);

   p_no_tmo_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_mode |-> iir_rdata[3:1] != 3'b110);

   p_reset_idle_r11: assert property (@(posedge clk)
      !rst_n |=> (iir_rdata == 8'h01 && ier_rdata == 8'h00) || !rst_n);
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (.*);

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
   localparam int CHAR_W = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              fifo_mode = 1'b0;
   logic              ls_overrun = 1'b0, ls_parity = 1'b0;
   logic              ls_framing = 1'b0, ls_break = 1'b0;
   logic              rx_ready = 1'b0, rx_empty = 1'b1;
   logic              rx_push = 1'b0, rx_pop = 1'b0, baud_tick = 1'b0;
   logic [CHAR_W-1:0] char_time = '0;
   logic              thr_empty = 1'b0;
   logic              ier_wr = 1'b0;
   logic [7:0]        wdata = '0;
   logic              thr_wr = 1'b0, iir_rd = 1'b0, lsr_rd = 1'b0, rbr_rd = 1'b0;
   logic [7:0]        ier_rdata, iir_rdata;
   logic              irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   uart_irq_ident #(.CHAR_W(CHAR_W)) dut (.*);

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk_iir(string req, logic [7:0] exp);
      checks++;
      if (iir_rdata !== exp || irq !== !exp[0]) begin
         errors++;
         $display("FAIL %s: iir=%h irq=%b expected iir=%h irq=%b",
                  req, iir_rdata, irq, exp, !exp[0]);
      end
   endtask

   task automatic chk_ier(string req, logic [7:0] exp);
      checks++;
      if (ier_rdata !== exp) begin
         errors++;
         $display("FAIL %s: ier=%h expected %h", req, ier_rdata, exp);
      end
   endtask

   task automatic write_ier(logic [7:0] v);
      ier_wr = 1'b1; wdata = v;
      step();
      ier_wr = 1'b0; wdata = '0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      chk_iir("R11 reset iir", 8'h01);
      chk_ier("R11 reset ier", 8'h00);
   endtask

   task automatic t_enable_reg();
      write_ier(8'hFF);
      chk_ier("R1 upper bits zero", 8'h07);
      write_ier(8'h00);
      chk_ier("R1 cleared", 8'h00);
   endtask

   task automatic t_line_status();
      ls_parity = 1'b1; step(); ls_parity = 1'b0;
      chk_iir("R2 masked line status", 8'h01);
      write_ier(8'h04);
      chk_iir("R2 held flag shown on enable", 8'h06);
      lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
      chk_iir("R5 lsr read clears", 8'h01);
      ls_break = 1'b1; step(); ls_break = 1'b0;
      chk_iir("R5 break sets", 8'h06);
      lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
      ls_overrun = 1'b1; step(); ls_overrun = 1'b0;
      chk_iir("R5 overrun sets", 8'h06);
      lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
      ls_framing = 1'b1; lsr_rd = 1'b1; step();
      ls_framing = 1'b0; lsr_rd = 1'b0;
      chk_iir("R5 event beats same-cycle read", 8'h06);
      lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
      chk_iir("R5 cleared after collision", 8'h01);
   endtask

   task automatic t_priority();
      write_ier(8'h07);
      thr_empty = 1'b1; step();
      chk_iir("R8 thr_empty rise", 8'h02);
      rx_ready = 1'b1; step();
      chk_iir("R4 data over transmit-empty", 8'h04);
      ls_overrun = 1'b1; step(); ls_overrun = 1'b0;
      chk_iir("R4 line status highest", 8'h06);
      iir_rd = 1'b1; step(); iir_rd = 1'b0;
      lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
      chk_iir("R4 data after line status", 8'h04);
      rx_ready = 1'b0; step();
      chk_iir("R9 unreported transmit-empty kept", 8'h02);
      iir_rd = 1'b1; step(); iir_rd = 1'b0;
      chk_iir("R9 iir read clears transmit-empty", 8'h01);
   endtask

   task automatic t_thr_empty();
      write_ier(8'h00);
      write_ier(8'h02);
      chk_iir("R8 enable while empty sets", 8'h02);
      thr_wr = 1'b1; thr_empty = 1'b0; step(); thr_wr = 1'b0;
      chk_iir("R8 thr write clears", 8'h01);
      thr_empty = 1'b1; step();
      chk_iir("R8 second rise", 8'h02);
      thr_wr = 1'b1; thr_empty = 1'b0; step(); thr_wr = 1'b0;
      chk_iir("R8 thr write clears again", 8'h01);
   endtask

   task automatic t_rx_data();
      write_ier(8'h01);
      rx_ready = 1'b1; step();
      chk_iir("R6 data available", 8'h04);
      rbr_rd = 1'b1; step(); rbr_rd = 1'b0;
      chk_iir("R6 rbr read clears", 8'h01);
      step();
      chk_iir("R6 re-raised while ready", 8'h04);
      rx_ready = 1'b0; step();
      chk_iir("R6 falls with ready", 8'h01);
   endtask

   task automatic t_timeout();
      fifo_mode = 1'b1; char_time = CHAR_W'(2); baud_tick = 1'b1;
      rx_empty = 1'b0; rx_push = 1'b1; step(); rx_push = 1'b0;
      repeat (7) step();
      chk_iir("R7 not yet expired", 8'h01);
      step();
      chk_iir("R7 expired after 8 ticks", 8'h0C);
      rx_ready = 1'b1; step();
      chk_iir("R4 data over timeout", 8'h04);
      rx_ready = 1'b0; step();
      chk_iir("R4 timeout shown again", 8'h0C);
      rbr_rd = 1'b1; step(); rbr_rd = 1'b0;
      chk_iir("R7 rbr read clears", 8'h01);
      repeat (10) step();
      chk_iir("R7 timer stops after expiry", 8'h01);
      rx_push = 1'b1; step(); rx_push = 1'b0;
      repeat (4) step();
      rx_pop = 1'b1; step(); rx_pop = 1'b0;
      repeat (7) step();
      chk_iir("R7 pop restarts timer", 8'h01);
      step();
      chk_iir("R7 expiry after pop restart", 8'h0C);
      rbr_rd = 1'b1; step(); rbr_rd = 1'b0;
      rx_empty = 1'b1; repeat (20) step();
      chk_iir("R7 held while empty", 8'h01);
   endtask

   task automatic t_non_fifo();
      fifo_mode = 1'b0;
      rx_empty = 1'b0; rx_push = 1'b1; step(); rx_push = 1'b0;
      repeat (12) step();
      chk_iir("R10 no timeout in single mode", 8'h01);
      fifo_mode = 1'b1; step();
      chk_iir("R10 timer was held", 8'h01);
      rx_empty = 1'b1; baud_tick = 1'b0;
   endtask

   initial begin
      #(20 * 50000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      step();
      t_reset();
      t_enable_reg();
      t_line_status();
      t_priority();
      t_thr_empty();
      t_rx_data();
      t_timeout();
      t_non_fifo();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule